// File: doc/BRIEF.md
# Write-Protected Retained Register Bank

This block is a bank of 16-bit user data registers that sits in an always-powered domain. Its contents survive anything that resets the main logic: a system reset, a main-domain power-on reset or a wake-up from a low-power state. The bank is cleared only by a dedicated retained-domain reset. A parameter picks the bank size: 42 registers (84 bytes) in the full configuration, or 10 registers (20 bytes) in the reduced one.

Software reaches the bank through a simple single-cycle register bus with one select, one write flag, an address and registered read data. Writes are locked out from reset onward. A write lands only when two conditions both hold. The interface clock enable must be high. The unlock input must also have been sampled high at an earlier clock edge, and a system reset clears that sampled state. Reads are never locked.

The block also drives a shared pin from a registered two-bit selector. The selector chooses a calibration clock, an alarm pulse, a seconds pulse or nothing. The pin is held low while the pin is assigned to tamper input.

Top module: `retained_reg_bank`

## Requirements
- R1: A high `bkp_rst` at a clock edge clears every data register to zero. A write sampled at the same edge is discarded.
- R2: `sys_rst` never changes the data registers. A write presented while `sys_rst` is high is discarded.
- R3: The unlock state is a register. `sys_rst` clears it, and at every other edge it loads `wr_unlock`. A write is accepted only when this register was already set before the write's edge. A write presented in the same cycle that `wr_unlock` first rises is dropped.
- R4: A write is accepted only while `clk_en` is high. With `clk_en` low the addressed register keeps its value.
- R5: While writes are locked, a read still returns the stored value.
- R6: A read (`bus_sel`=1, `bus_wr`=0) sampled at an edge places the addressed register on `bus_rdata` after that edge. A write takes effect at the edge where it is sampled, so a read of the same address in the following cycle returns the new value.
- R7: An address at or above the configured register count reads as zero. A write to such an address changes no register.
- R8: With `FULL_BANK`=1 the bank has 42 registers (addresses 0 to 41). With `FULL_BANK`=0 it has 10 registers (addresses 0 to 9), and addresses 10 and up read as zero.
- R9: `pin_out` is registered from `pin_sel`: 2'b00 gives 0, 2'b01 the calibration clock, 2'b10 the alarm pulse and 2'b11 the seconds pulse. Each value is sampled one edge earlier.
- R10: When `tamper_mode` is high at an edge, `pin_out` is 0 after that edge, whatever `pin_sel` is.
- R11: `sys_rst` clears `bus_rdata` to zero. When no read is sampled, `bus_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the retained logic |
| sys_rst | input | 1 | Synchronous main-domain reset; clears the lock state and the read data only |
| bkp_rst | input | 1 | Synchronous retained-domain reset; clears the data registers and the pin output |
| clk_en | input | 1 | Interface clock enable; a write needs it high |
| wr_unlock | input | 1 | Protection-disable request, sampled into the lock register |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Register index |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| tamper_mode | input | 1 | Pin is assigned to tamper input; forces the output low |
| pin_sel | input | 2 | Pin source: 00 off, 01 calibration clock, 10 alarm, 11 seconds |
| cal_clk | input | 1 | Calibration clock source |
| alarm_pulse | input | 1 | Alarm pulse source |
| sec_pulse | input | 1 | Seconds pulse source |
| pin_out | output | 1 | Registered shared-pin drive |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, a retained-domain reset and an unlocked write are driven on the same clock edge; the bench reads every register afterwards and expects all zeros, so the reset has won. In the second pair, the unlock input first rises in the same cycle as a write, and a write is also presented during a system reset; in both cases a read of the address must return the old value. The bench also reads a register in the cycle directly after writing it, to confirm the write-to-read timing.

// File: rtl/retbank_pkg.sv
package retbank_pkg;

  localparam int FULL_REGS  = 42;
  localparam int SMALL_REGS = 10;

  typedef enum logic [1:0] {
    PIN_OFF   = 2'b00,
    PIN_CAL   = 2'b01,
    PIN_ALARM = 2'b10,
    PIN_SEC   = 2'b11
  } pin_src_e;

  function automatic int bank_regs(input bit full);
    return full ? FULL_REGS : SMALL_REGS;
  endfunction

endpackage

// File: rtl/retbank_gate.sv
module retbank_gate #(
  parameter int NUM_REGS = 42,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              clk_en,
  input  logic              wr_unlock,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_ok,
  output logic              rd_req
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic unlock_q;
  logic in_range;

  // lock state lives in the main domain: any system reset re-locks
  always_ff @(posedge clk) begin
    if (sys_rst) unlock_q <= 1'b0;
    else         unlock_q <= wr_unlock;
  end

  assign in_range = ({1'b0, bus_addr} < LIMIT);
  assign wr_ok    = bus_sel & bus_wr & clk_en & unlock_q & ~sys_rst & in_range;
  assign rd_req   = bus_sel & ~bus_wr;

endmodule

// File: rtl/retbank_store.sv
module retbank_store #(
  parameter int NUM_REGS = 42,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              bkp_rst,
  input  logic              we,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_val;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_word
      always_ff @(posedge clk) begin
        if (bkp_rst)
          regs[gi] <= '0;
        else if (we && addr == ADDR_W'(gi))
          regs[gi] <= wdata;
      end
    end
  endgenerate

  // no index matches past the last word, so such reads give zero
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_val = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst)     rdata <= '0;
    else if (rd_req) rdata <= rd_val;
  end

endmodule

// File: rtl/retbank_pinmux.sv
module retbank_pinmux
  import retbank_pkg::*;
(
  input  logic       clk,
  input  logic       bkp_rst,
  input  logic       tamper_mode,
  input  logic [1:0] pin_sel,
  input  logic       cal_clk,
  input  logic       alarm_pulse,
  input  logic       sec_pulse,
  output logic       pin_out
);

  pin_src_e src;
  logic     nxt;

  assign src = pin_src_e'(pin_sel);

  always_comb begin
    unique case (src)
      PIN_CAL:   nxt = cal_clk;
      PIN_ALARM: nxt = alarm_pulse;
      PIN_SEC:   nxt = sec_pulse;
      default:   nxt = 1'b0;
    endcase
    if (tamper_mode) nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (bkp_rst) pin_out <= 1'b0;
    else         pin_out <= nxt;
  end

endmodule

// File: rtl/retained_reg_bank.sv
module retained_reg_bank #(
  parameter bit FULL_BANK = 1'b1,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              bkp_rst,
  input  logic              clk_en,
  input  logic              wr_unlock,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tamper_mode,
  input  logic [1:0]        pin_sel,
  input  logic              cal_clk,
  input  logic              alarm_pulse,
  input  logic              sec_pulse,
  output logic              pin_out
);

  localparam int NUM_REGS = retbank_pkg::bank_regs(FULL_BANK);

  logic wr_ok;
  logic rd_req;

  retbank_gate #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_gate (
    .clk      (clk),
    .sys_rst  (sys_rst),
    .clk_en   (clk_en),
    .wr_unlock(wr_unlock),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_ok    (wr_ok),
    .rd_req   (rd_req)
  );

  retbank_store #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_store (
    .clk    (clk),
    .sys_rst(sys_rst),
    .bkp_rst(bkp_rst),
    .we     (wr_ok),
    .rd_req (rd_req),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata)
  );

  retbank_pinmux u_pin (
    .clk        (clk),
    .bkp_rst    (bkp_rst),
    .tamper_mode(tamper_mode),
    .pin_sel    (pin_sel),
    .cal_clk    (cal_clk),
    .alarm_pulse(alarm_pulse),
    .sec_pulse  (sec_pulse),
    .pin_out    (pin_out)
  );

endmodule

// File: rtl/retbank_chk.sv
module retbank_chk #(
  parameter int NUM_REGS = 42,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 6
) (
  input logic              clk,
  input logic              sys_rst,
  input logic              bkp_rst,
  input logic              clk_en,
  input logic              wr_unlock,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tamper_mode,
  input logic [1:0]        pin_sel,
  input logic              cal_clk,
  input logic              alarm_pulse,
  input logic              sec_pulse,
  input logic              pin_out,
  input logic              wr_ok
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  // R3
  lock_before_write_chk: assert property (@(posedge clk) disable iff (sys_rst)
    wr_ok |-> $past(wr_unlock));

  // R4
  clken_for_write_chk: assert property (@(posedge clk) disable iff (sys_rst)
    wr_ok |-> clk_en);

  // R7
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (bus_sel && !bus_wr && ({1'b0, bus_addr} >= LIMIT)) |=> (bus_rdata == '0));

  // R11
  rdata_reset_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    sys_rst |=> (bus_rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  // R10
  tamper_quiet_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    tamper_mode |=> !pin_out);

  // R9
  pin_off_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    (!tamper_mode && pin_sel == 2'b00) |=> !pin_out);

  // R9
  pin_cal_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    (!tamper_mode && pin_sel == 2'b01) |=> (pin_out == $past(cal_clk)));

  // R9
  pin_alarm_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    (!tamper_mode && pin_sel == 2'b10) |=> (pin_out == $past(alarm_pulse)));

  // R9
  pin_sec_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    (!tamper_mode && pin_sel == 2'b11) |=> (pin_out == $past(sec_pulse)));

endmodule

bind retained_reg_bank retbank_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .sys_rst    (sys_rst),
  .bkp_rst    (bkp_rst),
  .clk_en     (clk_en),
  .wr_unlock  (wr_unlock),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .tamper_mode(tamper_mode),
  .pin_sel    (pin_sel),
  .cal_clk    (cal_clk),
  .alarm_pulse(alarm_pulse),
  .sec_pulse  (sec_pulse),
  .pin_out    (pin_out),
  .wr_ok      (wr_ok)
);

// File: tb/retained_reg_bank_test.sv
`timescale 1ns/1ps
module retained_reg_bank_test;

  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NF = 42;
  localparam int NS = 10;

  logic          clk = 1'b0;
  logic          sys_rst = 1'b1, bkp_rst = 1'b1;
  logic          clk_en = 1'b0, wr_unlock = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rdata, rdata_s;
  logic          tamper_mode = 1'b0;
  logic [1:0]    pin_sel = 2'b00;
  logic          cal_clk = 1'b0, alarm_pulse = 1'b0, sec_pulse = 1'b0;
  logic          pin_out, pin_out_s;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  retained_reg_bank uut (
    .clk(clk), .sys_rst(sys_rst), .bkp_rst(bkp_rst), .clk_en(clk_en),
    .wr_unlock(wr_unlock), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .tamper_mode(tamper_mode), .pin_sel(pin_sel), .cal_clk(cal_clk),
    .alarm_pulse(alarm_pulse), .sec_pulse(sec_pulse), .pin_out(pin_out)
  );

  retained_reg_bank #(.FULL_BANK(1'b0)) uut_small (
    .clk(clk), .sys_rst(sys_rst), .bkp_rst(bkp_rst), .clk_en(clk_en),
    .wr_unlock(wr_unlock), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
    .tamper_mode(tamper_mode), .pin_sel(pin_sel), .cal_clk(cal_clk),
    .alarm_pulse(alarm_pulse), .sec_pulse(sec_pulse), .pin_out(pin_out_s)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return 16'hC3A0 ^ DW'(i * 16'h0111);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [DW-1:0] d, output logic [DW-1:0] ds);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = rdata; ds = rdata_s;
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] d, ds;
    check("R11 rdata after reset", rdata, '0);
    check("R1 pin after retained reset", {15'd0, pin_out}, '0);
    bus_read(5, d, ds);
    check("R1 register cleared", d, '0);
  endtask

  task automatic t_lock();
    logic [DW-1:0] d, ds;
    clk_en = 1'b1; wr_unlock = 1'b0;
    bus_write(3, 16'hA5A5);
    bus_read(3, d, ds);
    check("R3 locked write ignored", d, '0);
    @(negedge clk);
    wr_unlock = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'd3; bus_wdata = 16'h5A5A;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(3, d, ds);
    check("R3 write in unlock cycle dropped", d, '0);
    bus_write(3, 16'hA5A5);
    bus_read(3, d, ds);
    check("R3 write after unlock", d, 16'hA5A5);
  endtask

  task automatic t_clk_en();
    logic [DW-1:0] d, ds;
    clk_en = 1'b0;
    bus_write(3, 16'h1111);
    clk_en = 1'b1;
    bus_read(3, d, ds);
    check("R4 write without clock enable", d, 16'hA5A5);
  endtask

  task automatic t_fill();
    logic [DW-1:0] d, ds;
    for (int i = 0; i < NF; i++) bus_write(i, pat(i));
    for (int i = 0; i < NF; i++) begin
      bus_read(i, d, ds);
      check("R6 full bank readback", d, pat(i));
      check("R8 reduced bank readback", ds, (i < NS) ? pat(i) : '0);
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'd7; bus_wdata = 16'h7E57;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R6 read right after write", rdata, 16'h7E57);
    repeat (3) @(negedge clk);
    check("R11 rdata held while idle", rdata, 16'h7E57);
    bus_write(7, pat(7));
  endtask

  task automatic t_out_of_range();
    logic [DW-1:0] d, ds;
    bus_write(50, 16'hDEAD);
    bus_write(NF, 16'hDEAD);
    bus_read(50, d, ds);
    check("R7 out-of-range read", d, '0);
    bus_read(63, d, ds);
    check("R7 top address read", d, '0);
    for (int i = 0; i < NF; i++) begin
      bus_read(i, d, ds);
      check("R7 no register disturbed", d, pat(i));
    end
  endtask

  task automatic t_sys_reset();
    logic [DW-1:0] d, ds;
    bus_read(4, d, ds);
    @(negedge clk);
    sys_rst = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'd2; bus_wdata = 16'h0BAD;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R11 rdata cleared by system reset", rdata, '0);
    sys_rst = 1'b0;
    wr_unlock = 1'b0;
    for (int i = 0; i < NF; i++) begin
      bus_read(i, d, ds);
      check("R2 retained across system reset", d, pat(i));
    end
    bus_write(4, 16'h4444);
    bus_read(4, d, ds);
    check("R5 locked read returns stored value", d, pat(4));
  endtask

  task automatic t_bkp_collide();
    logic [DW-1:0] d, ds;
    wr_unlock = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bkp_rst = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'd9; bus_wdata = 16'hBEEF;
    @(negedge clk);
    bkp_rst = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    for (int i = 0; i < NF; i++) begin
      bus_read(i, d, ds);
      check("R1 cleared, colliding write dropped", d, '0);
    end
  endtask

  task automatic pin_step(input logic [1:0] s, input logic tm,
                          input logic c, input logic a, input logic sp,
                          input logic exp, input string req);
    @(negedge clk);
    pin_sel = s; tamper_mode = tm; cal_clk = c; alarm_pulse = a; sec_pulse = sp;
    @(negedge clk);
    check(req, {15'd0, pin_out}, {15'd0, exp});
  endtask

  task automatic t_pin();
    pin_step(2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 select off");
    pin_step(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 calibration high");
    pin_step(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 calibration low");
    pin_step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 alarm high");
    pin_step(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 alarm low");
    pin_step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 seconds high");
    pin_step(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 seconds low");
    pin_step(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10 tamper forces low");
    pin_step(2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10 tamper forces low seconds");
    pin_step(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9 released after tamper");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    sys_rst = 1'b0; bkp_rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_lock();
    t_clk_en();
    t_fill();
    t_back_to_back();
    t_out_of_range();
    t_sys_reset();
    t_bkp_collide();
    t_pin();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1-sequence actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule